// File: doc/BRIEF.md
# Multi-Register Word Transfer Sequencer

This block takes one block-transfer request and breaks it into a series of single-word memory accesses, one for each register selected in a 16-bit bitmask. The request carries a base address, the bitmask, a load/store flag, a direction select and a writeback enable. The direction select chooses between increment-after (the default, select low) and decrement-before (select high). Accesses leave on a valid/ready memory port. Each access carries the register index and the word address. For a store, it also carries the register's value, which is read through a combinational register-file read port addressed by the block.

Load data returns on a response strobe. The block writes it into the register file by index on a dedicated write port. When the last access completes, the block raises a one-cycle done pulse. If writeback was requested, a writeback strobe rises in the same cycle, carrying the address of the last access and the index of the base register. Only one access is in flight at a time, and a new request is taken only while the block is idle. A request with an empty list is rejected with an error pulse.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_valid`, `done`, `err`, `wb_we` and `rf_we` are 0.
- R2: With `req_decr`=0 (increment-after), registers are transferred in ascending index order. The k-th access (k from 0) uses address base + 4k, so the lowest-numbered register is at the base.
- R3: With `req_decr`=1 (decrement-before), registers are transferred in descending index order. The k-th access uses address base − 4k, so the highest-numbered register is at the base, the highest address.
- R4: Consecutive accepted accesses of one transfer differ in address by exactly 4.
- R5: While `mem_valid`=1 and `mem_ready`=0, `mem_addr` and `mem_idx` hold steady. After a load is accepted, `mem_valid` stays 0 until `mem_rvalid` returns.
- R6: For a store (`req_load`=0), every access has `mem_write`=1 and `mem_wdata` equal to `rd_data` for `rd_idx` equal to `mem_idx`.
- R7: For a load (`req_load`=1), each `mem_rvalid` cycle results in `rf_we`=1 one cycle later, with `rf_widx` equal to the accessed index and `rf_wdata` equal to `mem_rdata`.
- R8: `done` is a single-cycle pulse. It rises one cycle after the final accepted store access, or one cycle after the final load response.
- R9: If `req_wb`=1, `wb_we` pulses together with `done`, with `wb_data` equal to the last access address (base ± 4(n−1)) and `wb_idx` equal to `req_base_idx`. If `req_wb`=0, `wb_we` stays 0.
- R10: A request with `req_mask`=0 produces an `err` pulse one cycle after acceptance, issues no memory access and no `done`, and leaves the block idle.
- R11: While a transfer is in progress, `req_ready` is 0 and `req_valid` is ignored: the access sequence and the count of `done` pulses are unchanged.
- R12: A list with exactly one register issues a single access at the base address, and writeback returns the base unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_base | input | AW | Base word address |
| req_mask | input | NREG | Register selection bitmask |
| req_load | input | 1 | 1 = load, 0 = store |
| req_decr | input | 1 | 1 = decrement-before, 0 = increment-after |
| req_wb | input | 1 | Write final address back to base register |
| req_base_idx | input | IW | Index of the base register |
| mem_valid | output | 1 | Memory access request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | Access is a store |
| mem_addr | output | AW | Word address of the access |
| mem_idx | output | IW | Register index of the access |
| mem_wdata | output | DW | Store data |
| mem_rvalid | input | 1 | Load response valid |
| mem_rdata | input | DW | Load response data |
| rd_idx | output | IW | Register-file read index |
| rd_data | input | DW | Register-file read data |
| rf_we | output | 1 | Load data write strobe |
| rf_widx | output | IW | Load data destination index |
| rf_wdata | output | DW | Load data |
| wb_we | output | 1 | Base writeback strobe |
| wb_idx | output | IW | Base register index for writeback |
| wb_data | output | AW | Writeback address (last access) |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Empty-list rejection pulse |

## Verification
Each result has a fixed latency. A request presented before a clock edge is taken at that edge. An empty-list request raises `err` one cycle after acceptance. A store access taken at an edge leaves the next index and address visible right after that edge. `done` and `wb_we` follow the final store handshake by one cycle, or the final load response by one cycle. `rf_we` follows each load response by one cycle. The bench drives `mem_ready`, `mem_rvalid` and the requests on falling edges, and logs each handshake on the falling edge before the rising edge that completes it. Every expected cycle number is counted in falling edges from that log, so checks on `done` and `rf_we` compare against the log entry plus exactly one.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/blkxfer_pick.sv
// Selects the next register from a remaining-set mask: lowest set bit
// when ascending, highest set bit when descending.
module blkxfer_pick #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  input  logic            descend,
  output logic [IW-1:0]   idx,
  output logic            any
);

  logic [IW-1:0] lo_idx;
  logic [IW-1:0] hi_idx;

  // lowest set bit: scan downward so the last hit is the smallest index
  always_comb begin
    lo_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) lo_idx = IW'(i);
    end
  end

  // highest set bit: scan upward so the last hit is the largest index
  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (mask[i]) hi_idx = IW'(i);
    end
  end

  assign idx = descend ? hi_idx : lo_idx;
  assign any = |mask;

endmodule

// File: rtl/blkxfer_addr.sv
// Word address register: loaded with the base, then stepped by one word.
module blkxfer_addr #(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          descend,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (start) begin
      addr <= base;
    end else if (adv) begin
      addr <= descend ? (addr - STEP) : (addr + STEP);
    end
  end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_base,
  input  logic [NREG-1:0] req_mask,
  input  logic            req_load,
  input  logic            req_decr,
  input  logic            req_wb,
  input  logic [IW-1:0]   req_base_idx,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [IW-1:0]   mem_idx,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic [IW-1:0]   rd_idx,
  input  logic [DW-1:0]   rd_data,
  output logic            rf_we,
  output logic [IW-1:0]   rf_widx,
  output logic [DW-1:0]   rf_wdata,
  output logic            wb_we,
  output logic [IW-1:0]   wb_idx,
  output logic [AW-1:0]   wb_data,
  output logic            done,
  output logic            err
);

  import blkxfer_pkg::*;

  seq_state_t      state_q;
  logic [NREG-1:0] rem_q;
  logic [IW-1:0]   cur_idx_q;
  logic            load_q;
  logic            desc_q;
  logic            wb_en_q;
  logic [IW-1:0]   base_idx_q;

  logic            done_q, err_q, wb_we_q, rf_we_q;
  logic [IW-1:0]   wb_idx_q, rf_widx_q;
  logic [AW-1:0]   wb_data_q;
  logic [DW-1:0]   rf_wdata_q;

  logic            is_idle;
  logic            accept;
  logic            start;
  logic            hs;
  logic            rsp;
  logic            step;
  logic [NREG-1:0] pick_mask;
  logic            pick_desc;
  logic [IW-1:0]   pick_idx;
  logic            pick_any;
  logic [AW-1:0]   addr_q;

  assign is_idle   = (state_q == ST_IDLE);
  assign accept    = req_valid && is_idle;
  assign start     = accept && (|req_mask);
  assign hs        = (state_q == ST_ISSUE) && mem_ready;
  assign rsp       = (state_q == ST_WAIT) && mem_rvalid;
  assign step      = (hs && !load_q) || rsp;

  // one picker serves both the first choice (from the request) and the
  // following ones (from the remaining set)
  assign pick_mask = is_idle ? req_mask : rem_q;
  assign pick_desc = is_idle ? req_decr : desc_q;

  blkxfer_pick #(.NREG(NREG)) u_pick (
    .mask    (pick_mask),
    .descend (pick_desc),
    .idx     (pick_idx),
    .any     (pick_any)
  );

  blkxfer_addr #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .base    (req_base),
    .adv     (step && pick_any),
    .descend (desc_q),
    .addr    (addr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      cur_idx_q  <= '0;
      load_q     <= 1'b0;
      desc_q     <= 1'b0;
      wb_en_q    <= 1'b0;
      base_idx_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q    <= ST_ISSUE;
            cur_idx_q  <= pick_idx;
            rem_q      <= req_mask & ~(NREG'(1) << pick_idx);
            load_q     <= req_load;
            desc_q     <= req_decr;
            wb_en_q    <= req_wb;
            base_idx_q <= req_base_idx;
          end
        end
        ST_ISSUE, ST_WAIT: begin
          if (hs && load_q) begin
            state_q <= ST_WAIT;
          end else if (step) begin
            if (pick_any) begin
              state_q   <= ST_ISSUE;
              cur_idx_q <= pick_idx;
              rem_q     <= rem_q & ~(NREG'(1) << pick_idx);
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // registered result strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      wb_we_q    <= 1'b0;
      wb_idx_q   <= '0;
      wb_data_q  <= '0;
      rf_we_q    <= 1'b0;
      rf_widx_q  <= '0;
      rf_wdata_q <= '0;
    end else begin
      done_q  <= step && !pick_any;
      wb_we_q <= step && !pick_any && wb_en_q;
      err_q   <= accept && !(|req_mask);
      rf_we_q <= rsp;
      if (step && !pick_any) begin
        wb_idx_q  <= base_idx_q;
        wb_data_q <= addr_q;
      end
      if (rsp) begin
        rf_widx_q  <= cur_idx_q;
        rf_wdata_q <= mem_rdata;
      end
    end
  end

  assign req_ready = is_idle;
  assign mem_valid = (state_q == ST_ISSUE);
  assign mem_write = !load_q;
  assign mem_addr  = addr_q;
  assign mem_idx   = cur_idx_q;
  assign rd_idx    = cur_idx_q;
  assign mem_wdata = rd_data;
  assign rf_we     = rf_we_q;
  assign rf_widx   = rf_widx_q;
  assign rf_wdata  = rf_wdata_q;
  assign wb_we     = wb_we_q;
  assign wb_idx    = wb_idx_q;
  assign wb_data   = wb_data_q;
  assign done      = done_q;
  assign err       = err_q;

endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [NREG-1:0] req_mask,
  input logic            req_decr,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic            mem_write,
  input logic [AW-1:0]   mem_addr,
  input logic [IW-1:0]   mem_idx,
  input logic            mem_rvalid,
  input logic            rf_we,
  input logic            wb_we,
  input logic            done,
  input logic            err
);

  logic          pend_q;
  logic          have_prev_q;
  logic          dir_q;
  logic [AW-1:0] prev_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      have_prev_q <= 1'b0;
      dir_q       <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      if (req_valid && req_ready) begin
        dir_q       <= req_decr;
        have_prev_q <= 1'b0;
      end else if (mem_valid && mem_ready) begin
        have_prev_q <= 1'b1;
        prev_addr_q <= mem_addr;
      end else if (done) begin
        have_prev_q <= 1'b0;
      end
      if (mem_valid && mem_ready && !mem_write) pend_q <= 1'b1;
      else if (mem_rvalid) pend_q <= 1'b0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_valid);

  // R4
  word_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && have_prev_q) |->
      (mem_addr == (dir_q ? prev_addr_q - AW'(WORD_BYTES) : prev_addr_q + AW'(WORD_BYTES))));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_idx)));

  // R5
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !mem_valid);

  // R7
  rf_write_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(mem_rvalid));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  wb_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    wb_we |-> done);

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(req_valid && req_ready && (req_mask == '0)));

  // R10
  err_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!mem_valid && !done));

endmodule

bind blkxfer_seq blkxfer_seq_chk #(.AW(AW), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_chk (.*);

// File: tb/tb_blkxfer_seq.sv
module tb_blkxfer_seq;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NREG = 16;
  localparam int IW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [AW-1:0]   req_base = '0;
  logic [NREG-1:0] req_mask = '0;
  logic            req_load = 1'b0;
  logic            req_decr = 1'b0;
  logic            req_wb = 1'b0;
  logic [IW-1:0]   req_base_idx = '0;
  logic            mem_valid;
  logic            mem_ready = 1'b0;
  logic            mem_write;
  logic [AW-1:0]   mem_addr;
  logic [IW-1:0]   mem_idx;
  logic [DW-1:0]   mem_wdata;
  logic            mem_rvalid = 1'b0;
  logic [DW-1:0]   mem_rdata = '0;
  logic [IW-1:0]   rd_idx;
  logic [DW-1:0]   rd_data;
  logic            rf_we;
  logic [IW-1:0]   rf_widx;
  logic [DW-1:0]   rf_wdata;
  logic            wb_we;
  logic [IW-1:0]   wb_idx;
  logic [AW-1:0]   wb_data;
  logic            done;
  logic            err;

  always #2 clk = ~clk;

  assign rd_data = 32'hC0DE_0000 + 32'(rd_idx) * 32'h111;

  blkxfer_seq dut (.*);

  int checks = 0;
  int errors = 0;

  // memory model and logs
  bit            stall_en = 0;
  int            rsp_delay = 0;
  int            ncyc = 0;
  bit            pend = 0;
  int            pwait = 0;
  logic [AW-1:0] pend_addr;
  int            hs_n, rsp_n, rf_n, done_n, wb_n, err_n, hold_bad, done_cyc;
  logic [AW-1:0] hs_addr [32];
  logic [IW-1:0] hs_idx [32];
  logic          hs_wr [32];
  logic [DW-1:0] hs_wdata [32];
  int            hs_cyc [32];
  int            rsp_cyc [32];
  logic [IW-1:0] rf_idx_l [32];
  logic [DW-1:0] rf_data_l [32];
  logic [AW-1:0] wb_data_l;
  logic [IW-1:0] wb_idx_l;
  bit            prev_stall = 0;
  logic [AW-1:0] prev_addr;
  logic [IW-1:0] prev_idx;

  task automatic clear_logs();
    hs_n = 0; rsp_n = 0; rf_n = 0; done_n = 0; wb_n = 0; err_n = 0; hold_bad = 0;
  endtask

  always @(negedge clk) begin
    ncyc++;
    if (rst) begin
      mem_ready  = 1'b0;
      mem_rvalid = 1'b0;
      pend = 0;
      prev_stall = 0;
    end else begin
      if (mem_rvalid) begin
        mem_rvalid = 1'b0;
      end else if (pend) begin
        if (pwait == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = pend_addr ^ 32'h5A5A_A5A5;
          if (rsp_n < 32) rsp_cyc[rsp_n] = ncyc;
          rsp_n++;
          pend = 0;
        end else begin
          pwait--;
        end
      end
      if (done) begin done_n++; done_cyc = ncyc; end
      if (err) err_n++;
      if (wb_we) begin wb_n++; wb_data_l = wb_data; wb_idx_l = wb_idx; end
      if (rf_we) begin
        if (rf_n < 32) begin rf_idx_l[rf_n] = rf_widx; rf_data_l[rf_n] = rf_wdata; end
        rf_n++;
      end
      if (prev_stall && !(mem_valid && mem_addr == prev_addr && mem_idx == prev_idx)) hold_bad++;
      if (pend && mem_valid) hold_bad++;
      mem_ready = !stall_en || (ncyc % 3 != 0);
      prev_stall = mem_valid && !mem_ready;
      prev_addr = mem_addr;
      prev_idx  = mem_idx;
      if (mem_valid && mem_ready) begin
        if (hs_n < 32) begin
          hs_addr[hs_n] = mem_addr; hs_idx[hs_n] = mem_idx;
          hs_wr[hs_n] = mem_write; hs_wdata[hs_n] = mem_wdata; hs_cyc[hs_n] = ncyc;
        end
        hs_n++;
        if (!mem_write) begin pend = 1; pwait = rsp_delay; pend_addr = mem_addr; end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] base, input logic [NREG-1:0] mask,
                       input bit ld, input bit dec, input bit wb, input logic [IW-1:0] bidx);
    @(negedge clk);
    clear_logs();
    req_base = base; req_mask = mask; req_load = ld; req_decr = dec;
    req_wb = wb; req_base_idx = bidx; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end();
    int t = 0;
    while (done_n + err_n == 0 && t < 3000) begin @(negedge clk); t++; end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_xfer(input logic [AW-1:0] base, input logic [NREG-1:0] mask,
                            input bit ld, input bit dec, input bit wb, input logic [IW-1:0] bidx);
    logic [IW-1:0] eidx [16];
    logic [AW-1:0] last;
    int n = 0;
    string ord = dec ? "R3" : "R2";
    if (dec) begin
      for (int i = NREG - 1; i >= 0; i--) if (mask[i]) begin eidx[n] = IW'(i); n++; end
    end else begin
      for (int i = 0; i < NREG; i++) if (mask[i]) begin eidx[n] = IW'(i); n++; end
    end
    chk(hs_n == n, ord, "access count", hs_n, n);
    for (int k = 0; k < n && k < hs_n; k++) begin
      logic [AW-1:0] ea = dec ? base - 32'(4 * k) : base + 32'(4 * k);
      chk(hs_idx[k] == eidx[k], ord, "access index", hs_idx[k], eidx[k]);
      chk(hs_addr[k] == ea, ord, "access address", hs_addr[k], ea);
      if (k > 0) begin
        logic [AW-1:0] d = dec ? hs_addr[k-1] - hs_addr[k] : hs_addr[k] - hs_addr[k-1];
        chk(d == 4, "R4", "address step", d, 4);
      end
      if (!ld) begin
        chk(hs_wr[k] == 1'b1, "R6", "store flag", hs_wr[k], 1);
        chk(hs_wdata[k] == 32'hC0DE_0000 + 32'(eidx[k]) * 32'h111, "R6", "store data",
            hs_wdata[k], 32'hC0DE_0000 + 32'(eidx[k]) * 32'h111);
      end else begin
        chk(hs_wr[k] == 1'b0, "R7", "load flag", hs_wr[k], 0);
      end
    end
    if (ld) begin
      chk(rf_n == n, "R7", "rf write count", rf_n, n);
      for (int k = 0; k < n && k < rf_n; k++) begin
        logic [AW-1:0] ea = dec ? base - 32'(4 * k) : base + 32'(4 * k);
        chk(rf_idx_l[k] == eidx[k], "R7", "rf index", rf_idx_l[k], eidx[k]);
        chk(rf_data_l[k] == (ea ^ 32'h5A5A_A5A5), "R7", "rf data", rf_data_l[k], ea ^ 32'h5A5A_A5A5);
      end
      if (rsp_n == n && n > 0)
        chk(done_cyc == rsp_cyc[n-1] + 1, "R8", "done after last response", done_cyc, rsp_cyc[n-1] + 1);
    end else if (hs_n == n && n > 0) begin
      chk(done_cyc == hs_cyc[n-1] + 1, "R8", "done after last store", done_cyc, hs_cyc[n-1] + 1);
    end
    chk(done_n == 1, "R8", "done pulses", done_n, 1);
    chk(hold_bad == 0, "R5", "hold/outstanding violations", hold_bad, 0);
    last = dec ? base - 32'(4 * (n - 1)) : base + 32'(4 * (n - 1));
    if (wb) begin
      chk(wb_n == 1, "R9", "writeback count", wb_n, 1);
      chk(wb_data_l == last, "R9", "writeback data", wb_data_l, last);
      chk(wb_idx_l == bidx, "R9", "writeback index", wb_idx_l, bidx);
    end else begin
      chk(wb_n == 0, "R9", "writeback suppressed", wb_n, 0);
    end
    chk(err_n == 0, "R10", "no error", err_n, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(mem_valid == 1'b0, "R1", "mem_valid after reset", mem_valid, 0);
    chk({done, err, wb_we, rf_we} == 4'b0, "R1", "strobes after reset", {done, err, wb_we, rf_we}, 0);
  endtask

  task automatic t_inc_store();
    stall_en = 0; rsp_delay = 0;
    issue(32'h0000_1000, 16'b1000_0100_1001_0010, 0, 0, 1, 4'd13);
    wait_end();
    check_xfer(32'h0000_1000, 16'b1000_0100_1001_0010, 0, 0, 1, 4'd13);
  endtask

  task automatic t_dec_store_stall();
    stall_en = 1; rsp_delay = 0;
    issue(32'h0000_2000, 16'h8431, 0, 1, 1, 4'd2);
    wait_end();
    check_xfer(32'h0000_2000, 16'h8431, 0, 1, 1, 4'd2);
  endtask

  task automatic t_inc_load();
    stall_en = 1; rsp_delay = 2;
    issue(32'h0000_3000, 16'h00F0, 1, 0, 0, 4'd1);
    wait_end();
    check_xfer(32'h0000_3000, 16'h00F0, 1, 0, 0, 4'd1);
  endtask

  task automatic t_dec_load_full();
    stall_en = 0; rsp_delay = 0;
    issue(32'h0000_8000, 16'hFFFF, 1, 1, 1, 4'd0);
    wait_end();
    check_xfer(32'h0000_8000, 16'hFFFF, 1, 1, 1, 4'd0);
  endtask

  task automatic t_single();
    stall_en = 0; rsp_delay = 1;
    issue(32'h0000_4440, 16'h0020, 0, 0, 1, 4'd7);
    wait_end();
    check_xfer(32'h0000_4440, 16'h0020, 0, 0, 1, 4'd7);
    chk(wb_data_l == 32'h0000_4440, "R12", "single inc writeback", wb_data_l, 32'h0000_4440);
    issue(32'h0000_5550, 16'h8000, 1, 1, 1, 4'd3);
    wait_end();
    check_xfer(32'h0000_5550, 16'h8000, 1, 1, 1, 4'd3);
    chk(hs_n == 1, "R12", "single dec access count", hs_n, 1);
    chk(wb_data_l == 32'h0000_5550, "R12", "single dec writeback", wb_data_l, 32'h0000_5550);
  endtask

  task automatic t_empty();
    @(negedge clk);
    clear_logs();
    req_base = 32'h0000_6000; req_mask = '0; req_load = 0; req_decr = 0;
    req_wb = 1; req_base_idx = 4'd5; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b1, "R10", "err one cycle after accept", err, 1);
    repeat (4) @(negedge clk);
    chk(err_n == 1, "R10", "err pulse count", err_n, 1);
    chk(hs_n == 0, "R10", "no access", hs_n, 0);
    chk(done_n == 0 && wb_n == 0, "R10", "no done or writeback", done_n + wb_n, 0);
    chk(req_ready == 1'b1, "R10", "idle after reject", req_ready, 1);
  endtask

  task automatic t_busy();
    int bad = 0;
    stall_en = 1; rsp_delay = 0;
    issue(32'h0000_7000, 16'h0F00, 0, 0, 0, 4'd9);
    req_mask = 16'h0003; req_base = 32'h0000_0100; req_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (req_ready) bad++;
    end
    req_valid = 1'b0;
    chk(bad == 0, "R11", "ready low while busy", bad, 0);
    wait_end();
    repeat (5) @(negedge clk);
    check_xfer(32'h0000_7000, 16'h0F00, 0, 0, 0, 4'd9);
    chk(done_n == 1, "R11", "busy request ignored", done_n, 1);
  endtask

  initial begin
    int t = 0;
    while (t < 100000) begin @(posedge clk); t++; end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", t);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_logs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_inc_store();
    t_dec_store_stall();
    t_inc_load();
    t_dec_load_full();
    t_single();
    t_empty();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule